// File: doc/BRIEF.md
# Diode Emulation Flag and PWM Output Override

This block keeps a single "diode emulation active" flag for one complementary PWM pair. Two comparator trip signals, one for the high threshold and one for the low threshold, are brought into the clock domain through a short synchronizer. The synchronized trips, together with a functional enable, a periodic sync strobe and a re-entry blocking counter, decide when hardware may raise the flag. Software can also raise or drop the flag with single-cycle write strobes. The flag is either re-evaluated at every sync event or held until software clears it, depending on the mode.

While the flag is set, each of the two PWM outputs is replaced by a value chosen from four options: the synchronized trip, its inverse, constant 0 or constant 1. Each output picks its own trip source. While the flag is clear, the outputs pass the normal PWM inputs through unchanged. An external trip-out event always drops the functional enable. When the bypass bit is set, that event also returns the outputs to the normal PWM signals for as long as it is present.

Top module: `diode_emu_ctrl`

## Requirements
- R1: After reset the flag and the enable read 0, and both outputs equal the PWM inputs.
- R2: While the enable is 0, trip inputs never set the flag.
- R3: In latched mode (mode input 1), a trip on either input sets the flag on the third rising clock edge after the trip input changes, and the flag stays set through sync events until a clear strobe arrives.
- R4: In cycle mode (mode input 0), at each sync event the flag takes the current hardware set condition, so it drops if no synchronized trip is present at that event and stays set if one is present. Between sync events a present trip with no trip gone does not clear it.
- R5: A trip-out pulse clears the enable on the next edge, and this takes priority over an enable write in the same cycle.
- R6: The force strobe sets the flag on the next edge, and the clear strobe clears it on the next edge. Force wins when both arrive in the same cycle. Force is never blocked by the re-entry window.
- R7: When the flag falls, hardware setting is blocked until N sync events have occurred, where N is the 8-bit delay. With N = 0 the flag can be set again on the very next edge.
- R8: While the flag is set, each output's select bit picks its source (0 = trip high, 1 = trip low). Its 2-bit drive code then gives 00 = synchronized source, 01 = inverted source, 10 = constant 0, 11 = constant 1.
- R9: While the flag is clear, each output equals its PWM input.
- R10: With bypass = 1, a present trip-out pulse makes both outputs equal their PWM inputs even while the flag is set. With bypass = 0 the override is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_hi_in | input | 1 | High comparator trip, asynchronous |
| trip_lo_in | input | 1 | Low comparator trip, asynchronous |
| sync_evt | input | 1 | Periodic sync event strobe |
| tripout_evt | input | 1 | External trip-out event |
| pwm_a_in | input | 1 | Normal PWM A |
| pwm_b_in | input | 1 | Normal PWM B |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wr_val | input | 1 | Value written to the enable bit |
| cfg_mode | input | 1 | 0 = cycle mode, 1 = latched mode |
| cfg_reentry_dly | input | 8 | Re-entry blocking length in sync events |
| cfg_bypass | input | 1 | Trip-out bypasses the override |
| cfg_sel_a | input | 1 | Trip source for A (0 high, 1 low) |
| cfg_drv_a | input | 2 | Drive code for A |
| cfg_sel_b | input | 1 | Trip source for B (0 high, 1 low) |
| cfg_drv_b | input | 2 | Drive code for B |
| force_wr | input | 1 | Write-1 strobe that sets the flag |
| clear_wr | input | 1 | Write-1 strobe that clears the flag |
| flag_out | output | 1 | Diode emulation active flag |
| enable_rd | output | 1 | Current enable bit |
| pwm_a_out | output | 1 | Final PWM A |
| pwm_b_out | output | 1 | Final PWM B |

## Verification
The bench sweeps every combination of select bit, drive code, trip levels and PWM input on both outputs. An output mux that swapped trip sources or mixed up the invert and constant codes would show up at once as a wrong output level. The re-entry window is probed with a delay of three, checking that the flag stays down through two sync events and rises after the third. A counter that decremented on every clock or was loaded late would let the flag in early or hold it off too long. Other runs target force-and-clear collisions, a trip-out that lands together with an enable write, and the exact synchronizer latency. A design that let clear win, let the write win, or used one flop too few would fail those checks.

// File: rtl/de_pkg.sv
package de_pkg;

    typedef enum logic {
        DE_MODE_CYCLE = 1'b0,
        DE_MODE_LATCH = 1'b1
    } de_mode_e;

    typedef enum logic [1:0] {
        DE_DRV_TRIP   = 2'b00,
        DE_DRV_INV    = 2'b01,
        DE_DRV_ZERO   = 2'b10,
        DE_DRV_ONE    = 2'b11
    } de_drv_e;

    typedef struct packed {
        logic flag;
        logic enable;
    } de_state_t;

endpackage

// File: rtl/de_trip_sync.sv
module de_trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/de_reentry_blk.sv
module de_reentry_blk #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic             sync_evt,
    output logic             blocked
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = dly;
        else if (sync_evt && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign blocked = (cnt_q != '0);
endmodule

// File: rtl/de_drive_mux.sv
module de_drive_mux
    import de_pkg::*;
(
    input  logic       trip_hi,
    input  logic       trip_lo,
    input  logic       sel,
    input  logic [1:0] drv,
    input  logic       active,
    input  logic       pwm_in,
    output logic       pwm_out
);
    logic src;
    logic ovr;

    always_comb begin
        src = sel ? trip_lo : trip_hi;
        unique case (de_drv_e'(drv))
            DE_DRV_TRIP: ovr = src;
            DE_DRV_INV:  ovr = ~src;
            DE_DRV_ZERO: ovr = 1'b0;
            DE_DRV_ONE:  ovr = 1'b1;
            default:     ovr = 1'b0;
        endcase
        pwm_out = active ? ovr : pwm_in;
    end
endmodule

// File: rtl/diode_emu_ctrl.sv
module diode_emu_ctrl
    import de_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_hi_in,
    input  logic             trip_lo_in,
    input  logic             sync_evt,
    input  logic             tripout_evt,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic             en_wr,
    input  logic             en_wr_val,
    input  logic             cfg_mode,
    input  logic [DLY_W-1:0] cfg_reentry_dly,
    input  logic             cfg_bypass,
    input  logic             cfg_sel_a,
    input  logic [1:0]       cfg_drv_a,
    input  logic             cfg_sel_b,
    input  logic [1:0]       cfg_drv_b,
    input  logic             force_wr,
    input  logic             clear_wr,
    output logic             flag_out,
    output logic             enable_rd,
    output logic             pwm_a_out,
    output logic             pwm_b_out
);
    localparam int NUM_CH = 2;

    de_state_t st_d, st_q;
    logic      trip_hi_s, trip_lo_s;
    logic      trip_any;
    logic      blocked;
    logic      hw_set;
    logic      flag_fall;
    logic      override_on;

    logic [NUM_CH-1:0]      ch_sel;
    logic [NUM_CH-1:0][1:0] ch_drv;
    logic [NUM_CH-1:0]      ch_pwm_in;
    logic [NUM_CH-1:0]      ch_pwm_out;

    de_trip_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .din(trip_hi_in), .dout(trip_hi_s)
    );
    de_trip_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .din(trip_lo_in), .dout(trip_lo_s)
    );

    de_reentry_blk #(.DLY_W(DLY_W)) u_reentry (
        .clk(clk), .rst_n(rst_n), .load(flag_fall), .dly(cfg_reentry_dly),
        .sync_evt(sync_evt), .blocked(blocked)
    );

    assign trip_any = trip_hi_s | trip_lo_s;

    always_comb begin
        st_d   = st_q;
        hw_set = st_q.enable && trip_any && !blocked;

        if (tripout_evt)
            st_d.enable = 1'b0;
        else if (en_wr)
            st_d.enable = en_wr_val;

        if (force_wr)
            st_d.flag = 1'b1;
        else if (clear_wr)
            st_d.flag = 1'b0;
        else if (de_mode_e'(cfg_mode) == DE_MODE_LATCH) begin
            if (hw_set) st_d.flag = 1'b1;
        end else begin
            if (sync_evt)    st_d.flag = hw_set;
            else if (hw_set) st_d.flag = 1'b1;
        end

        flag_fall = st_q.flag && !st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign override_on = st_q.flag && !(cfg_bypass && tripout_evt);

    assign ch_sel    = {cfg_sel_b, cfg_sel_a};
    assign ch_drv    = {cfg_drv_b, cfg_drv_a};
    assign ch_pwm_in = {pwm_b_in, pwm_a_in};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        de_drive_mux u_mux (
            .trip_hi(trip_hi_s), .trip_lo(trip_lo_s),
            .sel(ch_sel[g]), .drv(ch_drv[g]),
            .active(override_on), .pwm_in(ch_pwm_in[g]),
            .pwm_out(ch_pwm_out[g])
        );
    end

    assign pwm_a_out = ch_pwm_out[0];
    assign pwm_b_out = ch_pwm_out[1];
    assign flag_out  = st_q.flag;
    assign enable_rd = st_q.enable;
endmodule

// File: rtl/de_emu_checker.sv
module de_emu_checker (
    input logic clk,
    input logic rst_n,
    input logic tripout_evt,
    input logic pwm_a_in,
    input logic pwm_b_in,
    input logic cfg_mode,
    input logic force_wr,
    input logic clear_wr,
    input logic flag_out,
    input logic enable_rd,
    input logic pwm_a_out,
    input logic pwm_b_out
);
    assert_no_hw_set_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_wr && !enable_rd && !flag_out) |=> !flag_out);

    assert_latched_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && flag_out && !clear_wr) |=> flag_out);

    assert_tripout_drops_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tripout_evt |=> !enable_rd);

    assert_force_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> flag_out);

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !force_wr) |=> !flag_out);

    assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_out |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in));
endmodule

bind diode_emu_ctrl de_emu_checker u_de_emu_checker (
    .clk(clk), .rst_n(rst_n), .tripout_evt(tripout_evt),
    .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in), .cfg_mode(cfg_mode),
    .force_wr(force_wr), .clear_wr(clear_wr), .flag_out(flag_out),
    .enable_rd(enable_rd), .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out)
);

// File: tb/diode_emu_ctrl_bench.sv
`timescale 1ns/1ps
module diode_emu_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_hi_in = 0, trip_lo_in = 0, sync_evt = 0, tripout_evt = 0;
    logic pwm_a_in = 0, pwm_b_in = 0, en_wr = 0, en_wr_val = 0;
    logic cfg_mode = 0, cfg_bypass = 0, cfg_sel_a = 0, cfg_sel_b = 0;
    logic [7:0] cfg_reentry_dly = 8'd0;
    logic [1:0] cfg_drv_a = 2'd0, cfg_drv_b = 2'd0;
    logic force_wr = 0, clear_wr = 0;
    logic flag_out, enable_rd, pwm_a_out, pwm_b_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    diode_emu_ctrl u_diode_emu_ctrl (.*);

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_sync();
        sync_evt = 1; tick(1); sync_evt = 0;
    endtask

    function automatic logic exp_out(input logic sel, input logic [1:0] drv,
                                     input logic th, input logic tl);
        logic s;
        s = sel ? tl : th;
        case (drv)
            2'd0: return s;
            2'd1: return ~s;
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        pwm_a_in = 1; pwm_b_in = 0;
        #1;
        chk("R1 flag", flag_out, 0);
        chk("R1 enable", enable_rd, 0);
        chk("R1 pwm", {pwm_b_out, pwm_a_out}, 8'b01);
        rst_n = 1; tick(1);

        // R2 enable 0: trips ignored
        trip_hi_in = 1; trip_lo_in = 1; tick(4); pulse_sync(); tick(2);
        chk("R2 flag stays 0", flag_out, 0);
        trip_hi_in = 0; trip_lo_in = 0; tick(3);

        // R8 sweep with flag forced
        cfg_mode = 1; force_wr = 1; tick(1); force_wr = 0;
        for (int sa = 0; sa < 2; sa++)
            for (int da = 0; da < 4; da++)
                for (int th = 0; th < 2; th++)
                    for (int tl = 0; tl < 2; tl++)
                        for (int pa = 0; pa < 2; pa++) begin
                            cfg_sel_a = sa[0]; cfg_drv_a = da[1:0];
                            cfg_sel_b = ~sa[0]; cfg_drv_b = 2'(3 - da);
                            trip_hi_in = th[0]; trip_lo_in = tl[0];
                            pwm_a_in = pa[0]; pwm_b_in = ~pa[0];
                            tick(3);
                            chk("R8 out A", pwm_a_out,
                                exp_out(sa[0], da[1:0], th[0], tl[0]));
                            chk("R8 out B", pwm_b_out,
                                exp_out(~sa[0], 2'(3 - da), th[0], tl[0]));
                        end

        // R10 bypass
        cfg_sel_a = 0; cfg_drv_a = 2'd3; cfg_drv_b = 2'd2;
        pwm_a_in = 0; pwm_b_in = 1;
        cfg_bypass = 1; tripout_evt = 1; #1;
        chk("R10 bypass A", pwm_a_out, 0);
        chk("R10 bypass B", pwm_b_out, 1);
        cfg_bypass = 0; #1;
        chk("R10 no bypass", {pwm_b_out, pwm_a_out}, 8'b01);
        tick(1); tripout_evt = 0;

        // R6 force+clear collision, then clear
        clear_wr = 1; force_wr = 1; tick(1);
        chk("R6 force wins", flag_out, 1);
        force_wr = 0; tick(1); clear_wr = 0;
        chk("R6 clear", flag_out, 0);

        // R9 passthrough sweep
        for (int p = 0; p < 4; p++) begin
            pwm_a_in = p[0]; pwm_b_in = p[1]; #1;
            chk("R9 passthrough", {pwm_b_out, pwm_a_out}, 8'(p));
        end
        trip_hi_in = 0; trip_lo_in = 0; tick(3);

        // R5 trip-out clears enable, priority over write
        en_wr = 1; en_wr_val = 1; tick(1); en_wr = 0;
        chk("R5 enable set", enable_rd, 1);
        tripout_evt = 1; tick(1); tripout_evt = 0;
        chk("R5 tripout clears", enable_rd, 0);
        en_wr = 1; tripout_evt = 1; tick(1); en_wr = 0; tripout_evt = 0;
        chk("R5 tripout beats write", enable_rd, 0);
        en_wr = 1; tick(1); en_wr = 0;

        // R3 latched mode latency and hold
        cfg_mode = 1; trip_lo_in = 1; tick(2);
        chk("R3 not yet", flag_out, 0);
        tick(1);
        chk("R3 set on third edge", flag_out, 1);
        trip_lo_in = 0; tick(3); pulse_sync(); pulse_sync(); tick(1);
        chk("R3 held", flag_out, 1);
        clear_wr = 1; tick(1); clear_wr = 0;
        chk("R3 cleared", flag_out, 0);

        // R7 N=0: immediate re-set
        trip_hi_in = 1; tick(4);
        chk("R7 N0 set", flag_out, 1);
        clear_wr = 1; tick(1); clear_wr = 0;
        chk("R7 N0 clear edge", flag_out, 0);
        tick(1);
        chk("R7 N0 reset next edge", flag_out, 1);

        // R4 cycle mode
        cfg_mode = 0; pulse_sync();
        chk("R4 trip present keeps", flag_out, 1);
        trip_hi_in = 0; tick(4);
        chk("R4 no clear between syncs", flag_out, 1);
        pulse_sync();
        chk("R4 clear at sync", flag_out, 0);

        // R7 N=3 blocking
        cfg_reentry_dly = 8'd3;
        trip_hi_in = 1; tick(4);
        chk("R7 set", flag_out, 1);
        trip_hi_in = 0; tick(3); pulse_sync();
        chk("R7 cleared", flag_out, 0);
        trip_hi_in = 1; tick(4);
        chk("R7 blocked", flag_out, 0);
        pulse_sync(); pulse_sync(); tick(2);
        chk("R7 blocked after 2 syncs", flag_out, 0);
        pulse_sync();
        chk("R7 third sync edge", flag_out, 0);
        tick(1);
        chk("R7 released", flag_out, 1);

        // R6 force not blocked by window
        trip_hi_in = 0; tick(3); pulse_sync();
        chk("R6 dropped", flag_out, 0);
        force_wr = 1; tick(1); force_wr = 0;
        chk("R6 force ignores window", flag_out, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule